// File: doc/BRIEF.md
# Partitioned Scan Chain Controller

This block drives a scan chain that is split into `N_PART` equal partitions of `M_LEN` cells each. Only one partition shifts at any time. Before each load, the controller reads a partition index serially from the test data input. It then steers the scan-in bit into the chosen partition and brings that partition's last cell out on the test data output. The old contents are unloaded while the new stimulus is loaded.

A partition that is not loaded keeps the response it captured on the previous capture cycle. That response becomes its part of the next stimulus. A vector can therefore load as few as one partition, or several in turn. Each loaded partition is followed by a one-bit "more" flag that chooses between another index field and the capture cycle. On capture, every cell in every partition takes the response of a small built-in logic model of the circuit under test.

Top module: `pscan_top`

## Requirements
- R1: While rst_ni is low, the controller is idle. shift_en_o, capture_o and tdo_o are 0, and every scan cell is reset to 0.
- R2: A select phase lasts log2(N_PART) cycles. Each cycle takes one index bit from tdi_i, most significant bit first. No partition shifts and tdo_o is 0. The index takes effect only after its last bit.
- R3: A shift phase lasts M_LEN cycles. In each cycle, only shift_en_o[index] is high. tdi_i enters cell 0 of that partition, each cell moves to the next higher cell, and tdo_o shows the partition's highest cell (cell M_LEN-1) before the shift.
- R4: A partition whose shift enable is low keeps its contents on every cycle except a capture cycle.
- R5: The flag cycle follows every shift phase. tdi_i=1 starts another select phase and tdi_i=0 goes to capture. No shift happens and tdo_o is 0 during the flag cycle.
- R6: capture_o is high for exactly one cycle and no shift enable is high in that cycle. Every cell g = p*M_LEN+k then loads c[g] xor c[(g+1) mod L] xor (g odd). Here c is the chain contents before the capture and L = N_PART*M_LEN.
- R7: A vector that loads i partitions takes i*(log2(N_PART)+M_LEN+1) cycles of select, shift and flag, followed by one capture cycle.
- R8: When test_en_i is low, the cycle shifts nothing and captures nothing, and the controller is idle on the next cycle. Scan contents are kept and tdi_i is ignored while idle. When test_en_i is high in idle, a select phase starts on the next cycle.
- R9: One vector may load the same partition more than once. The loads take effect in order, and the second load unloads the data of the first.
- R10: After a capture with test_en_i high, the next cycle is the first select cycle of the next vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| test_en_i | input | 1 | Test mode enable; low aborts to idle |
| tdi_i | input | 1 | Serial index, data and flag bits |
| tdo_o | output | 1 | Serial unload of the active partition |
| shift_en_o | output | N_PART | Per-partition shift enables |
| capture_o | output | 1 | Global capture strobe |

## Verification
The bench loads partitions whose index bits are asymmetric, so a design that reads the index least significant bit first would shift the wrong partition. It checks tdo_o on every shift cycle against a reference model. A partition that drifted while frozen, or a capture that skipped unloaded partitions, therefore shows up when that partition is next unloaded. It loads one partition twice in a single vector. It also drops test_en_i in the middle of a shift, where a design that finished the shift or lost the partial contents would give the wrong unload data later. It times each capture strobe against the cycle count of the vector.

// File: rtl/pscan_pkg.sv
package pscan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SELECT,
    ST_SHIFT,
    ST_FLAG,
    ST_CAPTURE
  } pscan_state_e;
endpackage

// File: rtl/pscan_fsm.sv
module pscan_fsm
  import pscan_pkg::*;
#(
  parameter int N_PART = 4,
  parameter int M_LEN  = 8,
  localparam int SELW  = $clog2(N_PART),
  localparam int CW    = $clog2((M_LEN > SELW) ? M_LEN : SELW) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              test_en_i,
  input  logic              tdi_i,
  output logic [N_PART-1:0] shift_en_o,
  output logic              capture_o,
  output logic              shift_state_o,
  output logic [SELW-1:0]   sel_o
);
  pscan_state_e   state_q;
  logic [CW-1:0]  cnt_q;
  logic [SELW-1:0] idx_q;
  logic [SELW-1:0] sel_q;
  logic [SELW:0]  idx_cat;

  assign idx_cat = {idx_q, tdi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sel_q   <= '0;
    end else if (!test_en_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          state_q <= ST_SELECT;
          cnt_q   <= '0;
        end
        ST_SELECT: begin
          idx_q <= idx_cat[SELW-1:0];
          if (cnt_q == CW'(SELW - 1)) begin
            sel_q   <= idx_cat[SELW-1:0];
            state_q <= ST_SHIFT;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (cnt_q == CW'(M_LEN - 1)) begin
            state_q <= ST_FLAG;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_FLAG: begin
          state_q <= tdi_i ? ST_SELECT : ST_CAPTURE;
          cnt_q   <= '0;
        end
        ST_CAPTURE: begin
          state_q <= ST_SELECT;
          cnt_q   <= '0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar p = 0; p < N_PART; p++) begin : g_en
    assign shift_en_o[p] = test_en_i && (state_q == ST_SHIFT) && (sel_q == SELW'(p));
  end

  assign capture_o     = test_en_i && (state_q == ST_CAPTURE);
  assign shift_state_o = (state_q == ST_SHIFT);
  assign sel_o         = sel_q;

  // R3
  sel_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SHIFT && $past(state_q) == ST_SHIFT) |-> $stable(sel_q));
  // R6
  cap_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |-> (shift_en_o == '0));
  // R10
  after_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |=> (state_q == ST_SELECT || state_q == ST_IDLE));
  // R8
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_en_i |=> state_q == ST_IDLE);
  // R5
  flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FLAG && test_en_i) |=> (state_q == ST_SELECT || state_q == ST_CAPTURE));
endmodule

// File: rtl/pscan_part.sv
module pscan_part #(
  parameter int M_LEN = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_en_i,
  input  logic             capture_i,
  input  logic             sin_i,
  input  logic [M_LEN-1:0] resp_i,
  output logic [M_LEN-1:0] cells_o,
  output logic             sout_o
);
  logic [M_LEN-1:0] cells_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cells_q <= '0;
    else if (capture_i)  cells_q <= resp_i;
    else if (shift_en_i) cells_q <= {cells_q[M_LEN-2:0], sin_i};
  end

  assign cells_o = cells_q;
  assign sout_o  = cells_q[M_LEN-1];

  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(shift_en_i) && !$past(capture_i)) |-> $stable(cells_q));
endmodule

// File: rtl/pscan_cut.sv
module pscan_cut #(
  parameter int L_LEN = 32
) (
  input  logic [L_LEN-1:0] chain_i,
  output logic [L_LEN-1:0] resp_o
);
  for (genvar g = 0; g < L_LEN; g++) begin : g_resp
    assign resp_o[g] = chain_i[g] ^ chain_i[(g + 1) % L_LEN] ^ ((g % 2) == 1);
  end
endmodule

// File: rtl/pscan_top.sv
module pscan_top #(
  parameter int N_PART = 4,
  parameter int M_LEN  = 8,
  localparam int SELW  = $clog2(N_PART),
  localparam int L_LEN = N_PART * M_LEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              test_en_i,
  input  logic              tdi_i,
  output logic              tdo_o,
  output logic [N_PART-1:0] shift_en_o,
  output logic              capture_o
);
  logic             shift_state;
  logic [SELW-1:0]  sel;
  logic [L_LEN-1:0] chain;
  logic [L_LEN-1:0] resp;
  logic             sout [N_PART];

  pscan_fsm #(.N_PART(N_PART), .M_LEN(M_LEN)) u_fsm (
    .clk_i, .rst_ni, .test_en_i, .tdi_i,
    .shift_en_o, .capture_o,
    .shift_state_o(shift_state),
    .sel_o(sel)
  );

  pscan_cut #(.L_LEN(L_LEN)) u_cut (.chain_i(chain), .resp_o(resp));

  for (genvar p = 0; p < N_PART; p++) begin : g_part
    pscan_part #(.M_LEN(M_LEN)) u_part (
      .clk_i, .rst_ni,
      .shift_en_i(shift_en_o[p]),
      .capture_i(capture_o),
      .sin_i(tdi_i),
      .resp_i(resp[p*M_LEN +: M_LEN]),
      .cells_o(chain[p*M_LEN +: M_LEN]),
      .sout_o(sout[p])
    );
  end

  // scan-out mux
  assign tdo_o = shift_state ? sout[sel] : 1'b0;

  // R3
  one_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(shift_en_o));
  // R2
  idle_tdo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |-> !tdo_o);
endmodule

// File: tb/tb_pscan_top.sv
module tb_pscan_top;
  localparam int N = 4;
  localparam int M = 8;
  localparam int SW = 2;
  localparam int L = N * M;

  logic clk_i = 0;
  logic rst_ni = 0;
  logic test_en_i = 0;
  logic tdi_i = 0;
  logic tdo_o;
  logic [N-1:0] shift_en_o;
  logic capture_o;

  int errs = 0;
  int checks = 0;
  logic [M-1:0] mdl [N];

  pscan_top #(.N_PART(N), .M_LEN(M)) dut (.*);

  always #4 clk_i = ~clk_i;

  initial begin
    #1600000;
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // kind: 0 = no action, 1 = shift partition p, 2 = capture
  task automatic step(input logic en, input logic t, input int kind, input int p, input string r);
    logic [L-1:0] c;
    logic [N-1:0] exp_en;
    @(negedge clk_i);
    test_en_i = en;
    tdi_i = t;
    #1;
    exp_en = (kind == 1 && en) ? N'(1 << p) : '0;
    chk({r, " shift_en"}, 32'(shift_en_o), 32'(exp_en));
    chk({r, " tdo"}, 32'(tdo_o), (kind == 1) ? 32'(mdl[p][M-1]) : 32'd0);
    chk({r, " capture"}, 32'(capture_o), 32'(kind == 2 && en));
    @(posedge clk_i);
    if (en && kind == 1) mdl[p] = {mdl[p][M-2:0], t};
    if (en && kind == 2) begin
      for (int g = 0; g < L; g++) c[g] = mdl[g / M][g % M];
      for (int g = 0; g < L; g++) mdl[g / M][g % M] = c[g] ^ c[(g + 1) % L] ^ (g % 2 == 1);
    end
  endtask

  task automatic load(input int p, input logic [M-1:0] d, input logic more);
    for (int b = 0; b < SW; b++) step(1, p[SW-1-b], 0, 0, "R2 select");
    for (int b = 0; b < M; b++) step(1, d[b], 1, p, "R3 shift");
    step(1, more, 0, 0, "R5 flag");
  endtask

  task automatic capture();
    step(1, 0, 2, 0, "R6 R7 R10 capture");
  endtask

  initial begin
    for (int p = 0; p < N; p++) mdl[p] = '0;
    #2;
    #1;
    chk("R1 reset shift_en", 32'(shift_en_o), 0);
    chk("R1 reset tdo", 32'(tdo_o), 0);
    chk("R1 reset capture", 32'(capture_o), 0);
    #20 rst_ni = 1;
    // R8 idle ignores tdi
    step(0, 1, 0, 0, "R8 idle");
    step(0, 1, 0, 0, "R8 idle");
    step(1, 1, 0, 0, "R8 start");
    // vector 1: one partition, asymmetric index 1
    load(1, 8'hA5, 0);
    capture();
    // vector 2: partitions 2 then 0
    load(2, 8'h3C, 1);
    load(0, 8'hF0, 0);
    capture();
    // vector 3: partition 3 twice (R9)
    load(3, 8'h81, 1);
    load(3, 8'h5A, 0);
    capture();
    // vector 4: abort mid-shift (R8)
    for (int b = 0; b < SW; b++) step(1, b == 1, 0, 0, "R2 select");
    for (int b = 0; b < 3; b++) step(1, b[0], 1, 1, "R3 shift");
    step(0, 1, 1, 1, "R8 abort");
    step(0, 0, 0, 0, "R8 idle after abort");
    step(1, 0, 0, 0, "R8 restart");
    // full unload of every partition, R4 frozen contents
    load(0, 8'h11, 1);
    load(1, 8'h22, 1);
    load(2, 8'h44, 1);
    load(3, 8'h88, 0);
    capture();
    load(2, 8'h0F, 1);
    load(1, 8'h99, 1);
    load(0, 8'h66, 1);
    load(3, 8'h00, 0);
    step(0, 0, 2, 0, "R8 capture suppressed");
    step(1, 0, 0, 0, "R8 restart");
    load(3, 8'hC3, 1);
    load(0, 8'h00, 0);
    capture();
    load(1, 8'h00, 1);
    load(2, 8'h00, 0);
    capture();
    step(0, 0, 0, 0, "R8 idle");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule